// File: doc/BRIEF.md
# Dual-Clock Pairing FIFO (32-bit In, 64-bit Out)

This block moves data from a narrow, slower clock domain into a wider, faster one. Producers on the write clock push 32-bit words one at a time. Consumers on the read clock pull 64-bit words. Inside are two identical 32-bit dual-clock FIFO lanes. A small write controller steers successive accepted words into the lanes in turn. A single read strobe pops both lanes together and returns the two halves joined into one 64-bit word.

Each side has its own handshake. A write or read that can be honoured is acknowledged one cycle later. A write while full, or a read while empty, raises an error pulse instead and leaves the stored contents alone. Fill levels are reported in each domain. Each level is the local view of state held across the crossing, so it may trail the other side by a few cycles.

Top module: `dual_width_fifo_set`

## Requirements
- R1: After reset, rdEmpty is 1, wrFull is 0, wrCount and rdCount are 0, and wrAck, wrErr, rdAck and rdErr are all 0.
- R2: Accepted writes alternate between the lanes. The first word of each pair goes to the low lane and appears at rdData[31:0]. The second goes to the high lane and appears at rdData[63:32].
- R3: A read accepted at a rdClk edge pops both lanes. At the next edge rdAck is 1 and rdData holds {high word, low word} of the oldest pair.
- R4: rdEmpty stays 1 while either lane has no word. A pair with only its low half written is never delivered, and rdCount stays 0 for it.
- R5: wrFull is 1 exactly when the lane that the next write would target is full. This holds even while the other lane still has room. A write with wrFull at 1 gives wrErr 1 and wrAck 0 on the next wrClk cycle. The word is discarded, and the low/high pairing is not advanced.
- R6: A read with rdEmpty at 1 gives rdErr 1 and rdAck 0 on the next rdClk cycle, and no data is removed.
- R7: A write with wrFull at 0 gives wrAck 1 and wrErr 0 on the next wrClk cycle.
- R8: wrCount is the number of 32-bit words stored, as seen by the write side. rdCount is the number of complete 64-bit pairs available, as seen by the read side. Each lane holds DEPTH = 2^ADDR_W words, which is 8 by default.
- R9: Pairs leave in the order they were written, across the full depth of the lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrClk | input | 1 | Write-side clock |
| wrEn | input | 1 | Write strobe for one 32-bit word |
| wrData | input | DATA_W | Word to write |
| wrAck | output | 1 | Previous-cycle write accepted |
| wrErr | output | 1 | Previous-cycle write rejected because full |
| wrFull | output | 1 | Targeted lane is full |
| wrCount | output | ADDR_W+2 | 32-bit words held, write-side view |
| rdClk | input | 1 | Read-side clock |
| rdEn | input | 1 | Read strobe for one 64-bit word |
| rdData | output | 2*DATA_W | Joined pair {high lane, low lane} |
| rdAck | output | 1 | Previous-cycle read accepted |
| rdErr | output | 1 | Previous-cycle read rejected because empty |
| rdEmpty | output | 1 | No complete pair available |
| rdCount | output | ADDR_W+1 | Complete pairs available, read-side view |

## Verification
The bench goes after four boundaries. The first is a half-written pair. A design that reports non-empty on the low lane alone would hand out a 64-bit word with a stale high half. The second is the fill point one word short of full. A design that ORs both lane-full flags would then block a write that the high lane can still take. The third is a rejected write. If that write flips the lane selector, every later pair comes out with its halves swapped. The fourth is a read from empty. If it moves a pointer, the lanes fall out of step and the next delivered pair mixes words from different writes.

// File: rtl/fifo_set_pkg.sv
package fifo_set_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrLo;    // push low lane (write clock)
    logic wrHi;    // push high lane (write clock)
    logic rdBoth;  // pop both lanes (read clock)
  } ctrlStrobes_t;

  // Lane flags from datapath to control
  typedef struct packed {
    logic [1:0] laneFull;   // write-clock view
    logic [1:0] laneEmpty;  // read-clock view
  } laneStatus_t;

endpackage

// File: rtl/fifo_set_lane.sv
module fifo_set_lane #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              rstN,
  input  logic              wrClk,
  input  logic              push,
  input  logic [DATA_W-1:0] wrData,
  output logic              full,
  output logic [ADDR_W:0]   wrLevel,
  input  logic              rdClk,
  input  logic              pop,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic [ADDR_W:0]   rdLevel
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrBin, wrGray, rdBin, rdGray;
  logic [PTR_W-1:0]  rdGraySync1, rdGraySync2, wrGraySync1, wrGraySync2;

  // Write domain
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (push) begin
      wrBin  <= wrBin + 1'b1;
      wrGray <= toGray(wrBin + 1'b1);
    end
  end

  always_ff @(posedge wrClk) begin
    if (push) mem[wrBin[ADDR_W-1:0]] <= wrData;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      rdGraySync1 <= '0;
      rdGraySync2 <= '0;
    end else begin
      rdGraySync1 <= rdGray;
      rdGraySync2 <= rdGraySync1;
    end
  end

  assign full    = (wrGray == {~rdGraySync2[PTR_W-1:PTR_W-2], rdGraySync2[PTR_W-3:0]});
  assign wrLevel = wrBin - fromGray(rdGraySync2);

  // Read domain
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (pop) begin
      rdBin  <= rdBin + 1'b1;
      rdGray <= toGray(rdBin + 1'b1);
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      wrGraySync1 <= '0;
      wrGraySync2 <= '0;
    end else begin
      wrGraySync1 <= wrGray;
      wrGraySync2 <= wrGraySync1;
    end
  end

  assign empty   = (rdGray == wrGraySync2);
  assign rdLevel = fromGray(wrGraySync2) - rdBin;
  assign rdData  = mem[rdBin[ADDR_W-1:0]];

  // R5: control never pushes into a full lane
  p_no_overflow_r5: assert property (@(posedge wrClk) disable iff (!rstN)
    full |-> !push);
  // R6: control never pops an empty lane
  p_no_underflow_r6: assert property (@(posedge rdClk) disable iff (!rstN)
    empty |-> !pop);
  // R8: level never exceeds depth
  p_level_bound_r8: assert property (@(posedge wrClk) disable iff (!rstN)
    wrLevel <= (ADDR_W+1)'(DEPTH));

endmodule

// File: rtl/fifo_set_datapath.sv
module fifo_set_datapath
  import fifo_set_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                rstN,
  input  logic                wrClk,
  input  logic                rdClk,
  input  ctrlStrobes_t        strobes,
  input  logic [DATA_W-1:0]   wrData,
  output laneStatus_t         status,
  output logic [2*DATA_W-1:0] rdData,
  output logic [ADDR_W+1:0]   wrCount,
  output logic [ADDR_W:0]     rdCount
);
  localparam int LANES = 2;

  logic [DATA_W-1:0] laneOut   [LANES];
  logic [ADDR_W:0]   laneWrLvl [LANES];
  logic [ADDR_W:0]   laneRdLvl [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lanePush;
    assign lanePush = (g == 0) ? strobes.wrLo : strobes.wrHi;

    fifo_set_lane #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_lane (
      .rstN    (rstN),
      .wrClk   (wrClk),
      .push    (lanePush),
      .wrData  (wrData),
      .full    (status.laneFull[g]),
      .wrLevel (laneWrLvl[g]),
      .rdClk   (rdClk),
      .pop     (strobes.rdBoth),
      .rdData  (laneOut[g]),
      .empty   (status.laneEmpty[g]),
      .rdLevel (laneRdLvl[g])
    );
  end

  // Joined output register: high lane on top
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)                rdData <= '0;
    else if (strobes.rdBoth)  rdData <= {laneOut[1], laneOut[0]};
  end

  assign wrCount = {1'b0, laneWrLvl[0]} + {1'b0, laneWrLvl[1]};
  assign rdCount = (laneRdLvl[0] < laneRdLvl[1]) ? laneRdLvl[0] : laneRdLvl[1];

endmodule

// File: rtl/fifo_set_ctrl.sv
module fifo_set_ctrl
  import fifo_set_pkg::*;
(
  input  logic         rstN,
  input  logic         wrClk,
  input  logic         wrEn,
  output logic         wrAck,
  output logic         wrErr,
  output logic         wrFull,
  input  logic         rdClk,
  input  logic         rdEn,
  output logic         rdAck,
  output logic         rdErr,
  output logic         rdEmpty,
  input  laneStatus_t  status,
  output ctrlStrobes_t strobes
);
  logic wrSel;   // 0: next word to low lane, 1: to high lane
  logic wrTake;
  logic rdTake;

  assign wrFull  = status.laneFull[wrSel];
  assign wrTake  = wrEn && !wrFull;
  assign rdEmpty = |status.laneEmpty;
  assign rdTake  = rdEn && !rdEmpty;

  assign strobes.wrLo   = wrTake && !wrSel;
  assign strobes.wrHi   = wrTake &&  wrSel;
  assign strobes.rdBoth = rdTake;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrSel <= 1'b0;
      wrAck <= 1'b0;
      wrErr <= 1'b0;
    end else begin
      if (wrTake) wrSel <= ~wrSel;
      wrAck <= wrTake;
      wrErr <= wrEn && wrFull;
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdAck <= 1'b0;
      rdErr <= 1'b0;
    end else begin
      rdAck <= rdTake;
      rdErr <= rdEn && rdEmpty;
    end
  end

  // R2: at most one lane written per cycle
  p_one_lane_r2: assert property (@(posedge wrClk) disable iff (!rstN)
    $onehot0({strobes.wrLo, strobes.wrHi}));
  // R7: accepted write is acknowledged next cycle
  p_write_ack_r7: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrEn && !wrFull) |=> (wrAck && !wrErr));
  // R5: rejected write flags error and keeps the lane selector
  p_full_reject_r5: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrEn && wrFull) |=> (wrErr && !wrAck && $stable(wrSel)));
  // R6: read from empty flags error, no ack
  p_empty_reject_r6: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdEn && rdEmpty) |=> (rdErr && !rdAck));

endmodule

// File: rtl/dual_width_fifo_set.sv
module dual_width_fifo_set
  import fifo_set_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                rstN,
  input  logic                wrClk,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic                wrAck,
  output logic                wrErr,
  output logic                wrFull,
  output logic [ADDR_W+1:0]   wrCount,
  input  logic                rdClk,
  input  logic                rdEn,
  output logic [2*DATA_W-1:0] rdData,
  output logic                rdAck,
  output logic                rdErr,
  output logic                rdEmpty,
  output logic [ADDR_W:0]     rdCount
);
  ctrlStrobes_t strobes;
  laneStatus_t  status;

  fifo_set_ctrl i_ctrl (
    .rstN    (rstN),
    .wrClk   (wrClk),
    .wrEn    (wrEn),
    .wrAck   (wrAck),
    .wrErr   (wrErr),
    .wrFull  (wrFull),
    .rdClk   (rdClk),
    .rdEn    (rdEn),
    .rdAck   (rdAck),
    .rdErr   (rdErr),
    .rdEmpty (rdEmpty),
    .status  (status),
    .strobes (strobes)
  );

  fifo_set_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_datapath (
    .rstN    (rstN),
    .wrClk   (wrClk),
    .rdClk   (rdClk),
    .strobes (strobes),
    .wrData  (wrData),
    .status  (status),
    .rdData  (rdData),
    .wrCount (wrCount),
    .rdCount (rdCount)
  );

  // R4: a pop never happens while the read side reports empty
  p_no_half_pair_r4: assert property (@(posedge rdClk) disable iff (!rstN)
    rdEmpty |-> !strobes.rdBoth);

endmodule

// File: tb/test_dual_width_fifo_set.sv
module test_dual_width_fifo_set;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int DEPTH  = 1 << ADDR_W;

  logic rstN = 1'b0;
  logic wrClk = 1'b0;
  logic rdClk = 1'b0;
  logic wrEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic rdEn = 1'b0;
  logic wrAck, wrErr, wrFull, rdAck, rdErr, rdEmpty;
  logic [ADDR_W+1:0] wrCount;
  logic [ADDR_W:0]   rdCount;
  logic [2*DATA_W-1:0] rdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 rdClk = ~rdClk;   // 125 MHz read clock
  always #7 wrClk = ~wrClk;   // slower write clock

  dual_width_fifo_set #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dual_width_fifo_set (
    .rstN(rstN), .wrClk(wrClk), .wrEn(wrEn), .wrData(wrData),
    .wrAck(wrAck), .wrErr(wrErr), .wrFull(wrFull), .wrCount(wrCount),
    .rdClk(rdClk), .rdEn(rdEn), .rdData(rdData), .rdAck(rdAck),
    .rdErr(rdErr), .rdEmpty(rdEmpty), .rdCount(rdCount)
  );

  localparam logic [DATA_W-1:0] VEC_WORDS [8] = '{
    32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000,
    32'hA5A5_5A5A, 32'h5A5A_A5A5, 32'h1234_5678, 32'h9ABC_DEF0
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [DATA_W-1:0] d, output logic ack, output logic err);
    @(negedge wrClk); wrEn = 1'b1; wrData = d;
    @(negedge wrClk); wrEn = 1'b0;
    ack = wrAck; err = wrErr;
  endtask

  task automatic doRead(output logic [63:0] d, output logic ack, output logic err);
    @(negedge rdClk); rdEn = 1'b1;
    @(negedge rdClk); rdEn = 1'b0;
    d = rdData; ack = rdAck; err = rdErr;
  endtask

  task automatic settle();
    repeat (8) @(negedge rdClk);
    repeat (4) @(negedge wrClk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge rdClk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic a, e;
    logic [63:0] d;
    repeat (3) @(negedge wrClk);
    // R1 reset state
    check("R1 rdEmpty", 64'(rdEmpty), 64'd1);
    check("R1 wrFull",  64'(wrFull),  64'd0);
    check("R1 counts",  {32'(wrCount), 32'(rdCount)}, 64'd0);
    check("R1 strobes", {60'd0, wrAck, wrErr, rdAck, rdErr}, 64'd0);
    rstN = 1'b1;
    settle();

    // R2/R3/R7: vector table, one pair per entry pair
    for (int i = 0; i < 8; i += 2) begin
      doWrite(VEC_WORDS[i], a, e);
      check("R7 ack low word", {62'd0, a, e}, 64'b10);
      doWrite(VEC_WORDS[i+1], a, e);
      check("R7 ack high word", {62'd0, a, e}, 64'b10);
      settle();
      check("R8 rdCount one pair", 64'(rdCount), 64'd1);
      doRead(d, a, e);
      check("R2 R3 joined data", d, {VEC_WORDS[i+1], VEC_WORDS[i]});
      check("R3 read ack", {62'd0, a, e}, 64'b10);
    end
    settle();

    // R4: half-written pair is not visible
    doWrite(32'hDEAD_0001, a, e);
    settle();
    check("R4 empty on half pair", 64'(rdEmpty), 64'd1);
    check("R4 rdCount zero", 64'(rdCount), 64'd0);
    check("R8 wrCount one word", 64'(wrCount), 64'd1);
    // R6: read while empty rejected
    doRead(d, a, e);
    check("R6 empty read err", {62'd0, a, e}, 64'b01);
    doWrite(32'hDEAD_0002, a, e);
    settle();
    check("R4 pair now visible", 64'(rdEmpty), 64'd0);
    doRead(d, a, e);
    check("R6 R2 data after rejected read", d, 64'hDEAD0002_DEAD0001);
    settle();

    // R5/R8/R9: fill to full
    for (int k = 0; k < 2*DEPTH - 1; k++) begin
      doWrite(32'h100 + 32'(k), a, e);
      if (a !== 1'b1) check("R7 ack during fill", 64'(a), 64'd1);
    end
    settle();
    check("R5 high lane has room", 64'(wrFull), 64'd0);
    check("R8 wrCount 15", 64'(wrCount), 64'(2*DEPTH - 1));
    doWrite(32'h100 + 32'(2*DEPTH - 1), a, e);
    settle();
    check("R5 full", 64'(wrFull), 64'd1);
    check("R8 wrCount full", 64'(wrCount), 64'(2*DEPTH));
    check("R8 rdCount full", 64'(rdCount), 64'(DEPTH));
    doWrite(32'hBAD0_BAD0, a, e);
    check("R5 write on full rejected", {62'd0, a, e}, 64'b01);
    settle();
    check("R5 count unchanged", 64'(wrCount), 64'(2*DEPTH));
    for (int k = 0; k < DEPTH; k++) begin
      doRead(d, a, e);
      check("R9 ordered pair", d, {32'h100 + 32'(2*k + 1), 32'h100 + 32'(2*k)});
    end
    settle();
    check("R9 drained", 64'(rdEmpty), 64'd1);
    doRead(d, a, e);
    check("R6 read after drain", {62'd0, a, e}, 64'b01);

    // R5: rejected write left pairing intact, discarded word absent
    doWrite(32'hC0DE_0000, a, e);
    doWrite(32'hC0DE_0001, a, e);
    settle();
    doRead(d, a, e);
    check("R5 pairing after reject", d, 64'hC0DE0001_C0DE0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule